// File: doc/BRIEF.md
# Vectored Interrupt Controller with Automatic Context Save

This block arbitrates interrupt requests for a small nibble-wide microcontroller core. Four sources feed it: an external pin event and three timer underflow events. Each source has a latched request flag and an enable bit that the core supplies. There is also one global enable flag. At every instruction boundary the controller decides whether to take an interrupt.

When it takes one, it does four things:
- It sends the core a program-counter load with that source's fixed vector.
- It pushes the core's resume address onto a small return stack.
- It copies the data pointer, carry, skip flag and the A and B nibble registers into a one-entry shadow register.
- It clears the global enable and the serviced request flag.

A return instruction reverses this. It pops the resume address, drives it as the next program-counter load, and pulses a restore strobe while presenting the shadow contents. The enable instruction only arms the global enable. The flag is set when the next instruction completes. So an enable placed just before the return lets new interrupts in only once the main routine runs again.

The core's datapath, the timers and the instruction decode live outside this block. They reach it as strobes: boundary, enable-op and return-op. They also supply the resume address and the live context values.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the global enable is 0, every request flag is 0, and the PC-load and restore strobes are 0.
- R2: A source event sets that source's request flag. Repeated events while the flag is set still give only one service. An event in the same cycle that its source is accepted leaves the flag set.
- R3: An interrupt is accepted only on a cycle with the boundary strobe, and only when the global enable is 1 and the source's request flag and enable bit are both 1. No PC load results otherwise.
- R4: Acceptance of source i (external pin = 0, timers = 1, 2, 3) drives a one-cycle PC-load strobe on the next cycle. The target is page 1, offset 2*i, i.e. address 128 + 2*i with the default 7-bit page offset.
- R5: When several enabled requests are pending, the lowest source index is serviced first.
- R6: Acceptance clears the global enable to 0.
- R7: Acceptance clears only the serviced source's request flag; the other flags keep their values.
- R8: Acceptance pushes the resume address input. A return boundary (return-op with boundary strobe) pops it and drives it as the PC-load target on the next cycle.
- R9: Acceptance captures data pointer, carry, skip, A and B into the shadow register. A return boundary pulses the restore strobe on the next cycle, with the captured values on the context outputs.
- R10: An enable boundary does not set the global enable. The flag becomes 1 at the next boundary, and acceptance is judged on the flag as held before a boundary. A return boundary never accepts. An enable followed by a return therefore returns first, and the pending interrupt is taken at the following boundary.
- R11: Nested acceptances return in last-in, first-out order of their resume addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt_i | input | NSRC | Source event pulses (bit 0 external pin, bits 1..3 timers) |
| src_en_i | input | NSRC | Per-source enable bits |
| step_done_i | input | 1 | Instruction boundary strobe |
| op_ei_i | input | 1 | Completing instruction is the enable-interrupts op |
| op_rti_i | input | 1 | Completing instruction is the return-from-interrupt op |
| resume_pc_i | input | PC_W | Address of the next main-routine instruction |
| dp_i | input | DP_W | Live data pointer |
| cy_i | input | 1 | Live carry flag |
| sk_i | input | 1 | Live skip flag |
| a_i | input | NIB_W | Live register A |
| b_i | input | NIB_W | Live register B |
| pc_load_o | output | 1 | One-cycle program-counter load strobe |
| pc_target_o | output | PC_W | Vector or popped return address |
| ctx_restore_o | output | 1 | One-cycle context restore strobe |
| dp_o | output | DP_W | Saved data pointer |
| cy_o | output | 1 | Saved carry |
| sk_o | output | 1 | Saved skip flag |
| a_o | output | NIB_W | Saved register A |
| b_o | output | NIB_W | Saved register B |
| gie_o | output | 1 | Global interrupt enable flag |
| req_o | output | NSRC | Request flags |

## Verification
The hardest situation to reach is a request that becomes pending inside a service routine, followed by an enable op and then a return op. The controller must deliver the return address first and the vector only one boundary later. The bench reaches it by accepting one source, raising another source's event while the global enable is clear, and then issuing the enable and return boundaries in sequence. It checks the PC target at each step. Nesting is reached by re-enabling inside a routine so that a second acceptance stacks above the first. The two returns are then checked in reverse order.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int unsigned DP_W  = 10;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic [DP_W-1:0]  dp;
    logic             cy;
    logic             sk;
    logic [NIB_W-1:0] a;
    logic [NIB_W-1:0] b;
  } ctx_t;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            clr_i,
  output logic [NSRC-1:0] req_o,
  output logic [NSRC-1:0] gnt_o
);
  logic [NSRC-1:0] req_q, req_d, ready, blk;

  assign ready  = req_q & en_i;
  assign blk[0] = 1'b0;

  // fixed priority: lowest index wins
  for (genvar g = 1; g < NSRC; g++) begin : g_blk
    assign blk[g] = blk[g-1] | ready[g-1];
  end
  for (genvar g = 0; g < NSRC; g++) begin : g_gnt
    assign gnt_o[g] = ready[g] & ~blk[g];
  end

  always_comb begin
    req_d = req_q;
    if (clr_i) req_d = req_d & ~gnt_o;
    req_d = req_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((req_q & $past(req_q & ~gnt_o)) == $past(req_q & ~gnt_o)));
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((req_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int unsigned AW    = 13,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] top_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] sp_q, sp_d, top_idx;
  logic [PW:0]   lvl_q, lvl_d;

  always_comb begin
    sp_d  = sp_q;
    lvl_d = lvl_q;
    if (push_i) begin
      sp_d  = sp_q + 1'b1;
      lvl_d = lvl_q + 1'b1;
    end else if (pop_i) begin
      sp_d  = sp_q - 1'b1;
      lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      lvl_q <= '0;
    end else begin
      sp_q  <= sp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[sp_q] <= din_i;
  end

  assign top_idx = sp_q - 1'b1;
  assign top_o   = mem[top_idx];

  a_r8_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (lvl_q != '0));
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (lvl_q != (PW+1)'(DEPTH)));
endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow
  import irq_vc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  ctx_t din_i,
  output ctx_t dout_o
);
  ctx_t sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (cap_i) sh_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout_o = sh_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(sh_q));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vc_pkg::*;
#(
  parameter int unsigned NSRC   = 4,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned STK_D  = 4,
  localparam int unsigned PC_W  = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              step_done_i,
  input  logic              op_ei_i,
  input  logic              op_rti_i,
  input  logic [PC_W-1:0]   resume_pc_i,
  input  logic [DP_W-1:0]   dp_i,
  input  logic              cy_i,
  input  logic              sk_i,
  input  logic [NIB_W-1:0]  a_i,
  input  logic [NIB_W-1:0]  b_i,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_target_o,
  output logic              ctx_restore_o,
  output logic [DP_W-1:0]   dp_o,
  output logic              cy_o,
  output logic              sk_o,
  output logic [NIB_W-1:0]  a_o,
  output logic [NIB_W-1:0]  b_o,
  output logic              gie_o,
  output logic [NSRC-1:0]   req_o
);
  localparam int unsigned VEC_BASE = 1 << ADDR_W;  // page 1, offset 0

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  logic [NSRC-1:0] gnt;
  logic            accept, do_rti;
  logic            gie_q, gie_d, arm_q, arm_d;
  logic            load_q, load_d, rest_q, rest_d;
  logic [PC_W-1:0] tgt_q, tgt_d, vec, stk_top;
  ctx_t            live_ctx, saved_ctx;

  assign accept = step_done_i & gie_q & ~op_rti_i & (|gnt);
  assign do_rti = step_done_i & op_rti_i;

  irq_req_bank #(.NSRC(NSRC)) u_bank (
    .clk   (clk),
    .rst_n (rst_l),
    .evt_i (src_evt_i),
    .en_i  (src_en_i),
    .clr_i (accept),
    .req_o (req_o),
    .gnt_o (gnt)
  );

  irq_ret_stack #(.AW(PC_W), .DEPTH(STK_D)) u_stk (
    .clk    (clk),
    .rst_n  (rst_l),
    .push_i (accept),
    .pop_i  (do_rti),
    .din_i  (resume_pc_i),
    .top_o  (stk_top)
  );

  assign live_ctx = '{dp: dp_i, cy: cy_i, sk: sk_i, a: a_i, b: b_i};

  irq_ctx_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_l),
    .cap_i  (accept),
    .din_i  (live_ctx),
    .dout_o (saved_ctx)
  );

  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (gnt[i]) vec = vec | PC_W'(VEC_BASE + 2 * i);
  end

  always_comb begin
    gie_d = gie_q;
    arm_d = arm_q;
    if (step_done_i) begin
      if (accept) begin
        gie_d = 1'b0;
        arm_d = 1'b0;
      end else begin
        if (arm_q) gie_d = 1'b1;
        arm_d = op_ei_i;
      end
    end
    load_d = accept | do_rti;
    rest_d = do_rti;
    tgt_d  = tgt_q;
    if (accept)      tgt_d = vec;
    else if (do_rti) tgt_d = stk_top;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      gie_q  <= 1'b0;
      arm_q  <= 1'b0;
      load_q <= 1'b0;
      rest_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      gie_q  <= gie_d;
      arm_q  <= arm_d;
      load_q <= load_d;
      rest_q <= rest_d;
      tgt_q  <= tgt_d;
    end
  end

  assign pc_load_o     = load_q;
  assign pc_target_o   = tgt_q;
  assign ctx_restore_o = rest_q;
  assign gie_o         = gie_q;
  assign dp_o          = saved_ctx.dp;
  assign cy_o          = saved_ctx.cy;
  assign sk_o          = saved_ctx.sk;
  assign a_o           = saved_ctx.a;
  assign b_o           = saved_ctx.b;

  a_r6_gie_cleared: assert property (@(posedge clk) disable iff (!rst_l)
    accept |=> !gie_q);
  a_r10_ei_not_immediate: assert property (@(posedge clk) disable iff (!rst_l)
    (step_done_i && op_ei_i && !gie_q) |=> !gie_q);
  a_r4_vector_page: assert property (@(posedge clk) disable iff (!rst_l)
    (pc_load_o && !ctx_restore_o) |->
      (pc_target_o[0] == 1'b0 && pc_target_o[PC_W-1:ADDR_W] == PAGE_W'(1)));
  a_r3_needs_gie: assert property (@(posedge clk) disable iff (!rst_l)
    (pc_load_o && !ctx_restore_o) |-> $past(gie_q && step_done_i));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
  localparam int NSRC = 4;
  localparam int PC_W = 13;
  localparam int DP_W = irq_vc_pkg::DP_W;
  localparam int NW   = irq_vc_pkg::NIB_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_evt = '0, src_en = '1;
  logic step_done = 1'b0, op_ei = 1'b0, op_rti = 1'b0;
  logic [PC_W-1:0] resume_pc = '0;
  logic [DP_W-1:0] dp = '0;
  logic cy = 1'b0, sk = 1'b0;
  logic [NW-1:0] a = '0, b = '0;
  logic pc_load, ctx_restore, gie, cy_o, sk_o;
  logic [PC_W-1:0] pc_target;
  logic [DP_W-1:0] dp_o;
  logic [NW-1:0] a_o, b_o;
  logic [NSRC-1:0] req;

  always #2 clk = ~clk;

  irq_vec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .src_en_i(src_en),
    .step_done_i(step_done), .op_ei_i(op_ei), .op_rti_i(op_rti),
    .resume_pc_i(resume_pc), .dp_i(dp), .cy_i(cy), .sk_i(sk), .a_i(a), .b_i(b),
    .pc_load_o(pc_load), .pc_target_o(pc_target), .ctx_restore_o(ctx_restore),
    .dp_o(dp_o), .cy_o(cy_o), .sk_o(sk_o), .a_o(a_o), .b_o(b_o),
    .gie_o(gie), .req_o(req)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs applied at a falling edge, outputs read at the next
  task automatic cyc(logic d, logic ei, logic rti, logic [NSRC-1:0] ev);
    step_done = d; op_ei = ei; op_rti = rti; src_evt = ev;
    @(negedge clk);
    step_done = 1'b0; op_ei = 1'b0; op_rti = 1'b0; src_evt = '0;
  endtask

  function automatic logic [31:0] vec_of(int s);
    return 32'(128 + 2 * s);
  endfunction

  task automatic leave_isr();
    cyc(1, 1, 0, '0);
    cyc(1, 0, 1, '0);
  endtask

  task automatic t_reset();
    chk("R1 gie", gie, 0);
    chk("R1 req", req, 0);
    chk("R1 pc_load", pc_load, 0);
    chk("R1 restore", ctx_restore, 0);
  endtask

  task automatic t_enable();
    cyc(1, 1, 0, '0);
    chk("R10 gie after EI boundary", gie, 0);
    cyc(1, 0, 0, '0);
    chk("R10 gie after next boundary", gie, 1);
  endtask

  task automatic t_vectors();
    for (int s = 0; s < NSRC; s++) begin
      logic [PC_W-1:0] ret = PC_W'(13'h0400 + s * 16);
      logic [19:0] ctx_exp = {10'(37 * s + 5), 1'b1, s[0], 4'(s + 3), 4'(9 - s)};
      cyc(0, 0, 0, NSRC'(1 << s));
      chk("R2 flag set", req, 32'(1 << s));
      resume_pc = ret;
      {dp, cy, sk, a, b} = ctx_exp;
      cyc(1, 0, 0, '0);
      chk("R4 load", pc_load, 1);
      chk("R4 vector", pc_target, vec_of(s));
      chk("R6 gie cleared", gie, 0);
      chk("R7 flag cleared", req, 0);
      resume_pc = '1;
      {dp, cy, sk, a, b} = ~ctx_exp;
      cyc(1, 1, 0, '0);
      chk("R10 no load on EI", pc_load, 0);
      cyc(1, 0, 1, '0);
      chk("R8 return load", pc_load, 1);
      chk("R8 return target", pc_target, 32'(ret));
      chk("R9 restore strobe", ctx_restore, 1);
      chk("R9 context", {dp_o, cy_o, sk_o, a_o, b_o}, 32'(ctx_exp));
      chk("R10 gie back", gie, 1);
    end
  endtask

  task automatic t_priority();
    cyc(0, 0, 0, 4'b1110);
    cyc(1, 0, 0, '0);
    chk("R5 first", pc_target, vec_of(1));
    chk("R7 others kept", req, 4'b1100);
    leave_isr();
    cyc(1, 0, 0, '0);
    chk("R5 second", pc_target, vec_of(2));
    chk("R7 others kept 2", req, 4'b1000);
    leave_isr();
    cyc(1, 0, 0, '0);
    chk("R5 third", pc_target, vec_of(3));
    chk("R7 all clear", req, 0);
    leave_isr();
  endtask

  task automatic t_gating();
    src_en = 4'b1110;
    cyc(0, 0, 0, 4'b0001);
    cyc(1, 0, 0, '0);
    chk("R3 masked no load", pc_load, 0);
    chk("R3 masked flag kept", req, 4'b0001);
    src_en = '1;
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, '0);
      chk("R3 no load mid-instruction", pc_load, 0);
    end
    cyc(1, 0, 0, '0);
    chk("R3 load at boundary", pc_target, vec_of(0));
    cyc(0, 0, 0, 4'b0010);
    cyc(1, 0, 0, '0);
    chk("R3 no load with gie 0", pc_load, 0);
    chk("R3 pending kept", req, 4'b0010);
    leave_isr();
    chk("R10 return before pending", pc_load, 1);
    cyc(1, 0, 0, '0);
    chk("R10 pending taken next", pc_target, vec_of(1));
    leave_isr();
  endtask

  task automatic t_ei_before_rti();
    resume_pc = 13'h0777;
    cyc(0, 0, 0, 4'b0001);
    cyc(1, 0, 0, '0);
    chk("R4 vector ext", pc_target, vec_of(0));
    cyc(0, 0, 0, 4'b0100);
    cyc(1, 1, 0, '0);
    chk("R10 EI no load", pc_load, 0);
    cyc(1, 0, 1, '0);
    chk("R10 RTI returns first", pc_target, 32'h0777);
    chk("R10 RTI gie", gie, 1);
    cyc(1, 0, 0, '0);
    chk("R10 then vector", pc_target, vec_of(2));
    chk("R10 load", pc_load, 1);
    leave_isr();
  endtask

  task automatic t_duplicate();
    cyc(0, 0, 0, 4'b1000);
    cyc(0, 0, 0, 4'b1000);
    cyc(1, 0, 0, '0);
    chk("R2 dup vector", pc_target, vec_of(3));
    chk("R2 dup cleared", req, 0);
    leave_isr();
    cyc(1, 0, 0, '0);
    chk("R2 no second service", pc_load, 0);
    cyc(0, 0, 0, 4'b1000);
    cyc(1, 0, 0, 4'b1000);
    chk("R2 same-cycle accept", pc_target, vec_of(3));
    chk("R2 same-cycle flag kept", req, 4'b1000);
    leave_isr();
    cyc(1, 0, 0, '0);
    chk("R2 re-serviced", pc_target, vec_of(3));
    leave_isr();
  endtask

  task automatic t_nest();
    resume_pc = 13'h0123;
    cyc(0, 0, 0, 4'b0010);
    cyc(1, 0, 0, '0);
    chk("R11 outer vector", pc_target, vec_of(1));
    cyc(1, 1, 0, '0);
    cyc(1, 0, 0, '0);
    chk("R11 gie in ISR", gie, 1);
    resume_pc = 13'h0456;
    cyc(0, 0, 0, 4'b0001);
    cyc(1, 0, 0, '0);
    chk("R11 inner vector", pc_target, vec_of(0));
    resume_pc = '0;
    leave_isr();
    chk("R11 inner return", pc_target, 32'h0456);
    cyc(1, 0, 1, '0);
    chk("R11 outer return", pc_target, 32'h0123);
    chk("R11 outer load", pc_load, 1);
  endtask

  bit finished = 0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_vectors();
    t_priority();
    t_gating();
    t_ei_before_rti();
    t_duplicate();
    t_nest();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule